// File: doc/BRIEF.md
# NAND Flash Single-Error-Correcting Parity Unit

This block sits on the byte path between a NAND flash interface and the host. It builds a Hamming-style parity code from every qualified byte, whether the byte is being read or written. The unit has two independent accumulators. One covers the main data area of a page and the other covers the spare area. Each accumulator has a clear pulse and a freeze level of its own, so software can close the main code after the last page byte and then open the spare code for the bytes that follow.

On a write, software reads the finished code and stores it in flash. On a read, software loads the stored code into a per-area reference register. The block then XORs that reference with the locally computed code. It reports whether the data is clean, holds one correctable bit (with its byte and bit address), has several flipped bits, or has a single flip inside the stored code itself. A mode input parks the unit whenever a different correction scheme is selected.

Top module: `nand_hecc`

## Requirements
- R1: When `ecc_mode_i` is 0, `main_lock_i` is 0 and `byte_vld_i` is 1, the byte updates the main code and advances the main byte index. The code layout from LSB to MSB is as follows. Bits [2:0] hold col_lo[j], the XOR of the data bits whose bit number has bit j clear. Bits [5:3] hold col_hi[j], for bit number bit j set. The next AW bits hold line_lo[k], the XOR of all bits of bytes whose index has bit k clear. The top AW bits hold line_hi[k], for index bit k set. AW is 11 for main and 6 for spare.
- R2: While `main_lock_i` is 1, `main_code_o` holds its value whatever bytes arrive.
- R3: A one-cycle pulse on `main_init_i` (or `spare_init_i`) clears that area's code to zero and restarts its byte index at 0. This happens regardless of lock or mode.
- R4: The spare code follows the R1 layout with AW=6 under `spare_lock_i`. Its index wraps after 64 bytes. Main and spare accumulators never affect each other.
- R5: While `ecc_mode_i` is 1, no byte changes either code.
- R6: A write strobe loads the reference register at the clock edge. Status is 2'b00 when the reference equals the computed code.
- R7: Status is 2'b01 when the XOR of reference and code has every hi/lo pair differing. This happens for a single data-bit flip. The error byte output is then the line_hi part of that XOR and the error bit output is its col_hi part.
- R8: Status is 2'b10 for any other non-zero XOR that is not a single bit.
- R9: Status is 2'b11 when the XOR has exactly one bit set, meaning the stored code took the hit.
- R10: The error byte and bit outputs read zero unless the status is 2'b01.
- R11: While an area is locked and its reference is not written, its status and location outputs hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ecc_mode_i | input | 1 | 0 selects this single-bit mode, 1 parks the unit |
| byte_vld_i | input | 1 | Qualifies `byte_i` for one cycle |
| byte_i | input | 8 | Data byte crossing the flash interface |
| main_init_i | input | 1 | Clears main code and index |
| main_lock_i | input | 1 | Freezes main code when 1 |
| spare_init_i | input | 1 | Clears spare code and index |
| spare_lock_i | input | 1 | Freezes spare code when 1 |
| main_ref_wr_i | input | 1 | Loads `main_ref_i` |
| main_ref_i | input | 28 | Stored main-area code |
| spare_ref_wr_i | input | 1 | Loads `spare_ref_i` |
| spare_ref_i | input | 18 | Stored spare-area code |
| main_code_o | output | 28 | Computed main-area code |
| spare_code_o | output | 18 | Computed spare-area code |
| main_stat_o | output | 2 | Main status (00/01/10/11) |
| main_err_byte_o | output | 11 | Main faulty byte index |
| main_err_bit_o | output | 3 | Main faulty bit number |
| spare_stat_o | output | 2 | Spare status |
| spare_err_byte_o | output | 6 | Spare faulty byte index |
| spare_err_bit_o | output | 3 | Spare faulty bit number |

## Verification
The checker watches the invariants that hold on every edge. These are: frozen codes under lock, zeroed codes after init, no change while another mode is selected, status held while a locked area's reference is untouched, and location outputs held at zero outside the correctable case. Only the bench scenarios can show that the code values match the column and line parity layout for real byte streams, and that the spare index wraps correctly at 64 bytes. They also show that each status class comes from the corresponding corruption: a flipped data bit, two flipped bits, or a flipped stored parity bit. Finally, they show that the reported byte and bit point at the flipped bit.

// File: rtl/nand_hecc_pkg.sv
package nand_hecc_pkg;
  typedef enum logic [1:0] {
    HS_CLEAN  = 2'b00,
    HS_FIX    = 2'b01,
    HS_MULTI  = 2'b10,
    HS_PARITY = 2'b11
  } hecc_stat_e;

  localparam int COL_W = 3;

  // column parity of a byte, split by bit-number address
  function automatic logic [2*COL_W-1:0] col_par(input logic [7:0] d);
    logic [COL_W-1:0] hi, lo;
    for (int j = 0; j < COL_W; j++) begin
      hi[j] = 1'b0;
      lo[j] = 1'b0;
      for (int b = 0; b < 8; b++) begin
        if (((b >> j) & 1) == 1) hi[j] = hi[j] ^ d[b];
        else                     lo[j] = lo[j] ^ d[b];
      end
    end
    return {hi, lo};
  endfunction
endpackage

// File: rtl/nand_hecc_acc.sv
module nand_hecc_acc
  import nand_hecc_pkg::*;
#(
  parameter int AW = 11,
  localparam int CW = 2*AW + 2*COL_W
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          init_i,
  input  logic          upd_i,
  input  logic [7:0]    byte_i,
  output logic [CW-1:0] code_o
);
  logic [AW-1:0] idx_q;
  logic [AW-1:0] lhi_q, llo_q;
  logic [2*COL_W-1:0] col_q;
  logic par;

  assign par = ^byte_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      idx_q <= '0;
      lhi_q <= '0;
      llo_q <= '0;
      col_q <= '0;
    end else if (init_i) begin
      idx_q <= '0;
      lhi_q <= '0;
      llo_q <= '0;
      col_q <= '0;
    end else if (upd_i) begin
      idx_q <= idx_q + 1'b1;
      lhi_q <= lhi_q ^ ({AW{par}} & idx_q);
      llo_q <= llo_q ^ ({AW{par}} & ~idx_q);
      col_q <= col_q ^ col_par(byte_i);
    end
  end

  assign code_o = {lhi_q, llo_q, col_q};
endmodule

// File: rtl/nand_hecc_chk.sv
module nand_hecc_chk
  import nand_hecc_pkg::*;
#(
  parameter int AW = 11,
  localparam int CW = 2*AW + 2*COL_W
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          ref_wr_i,
  input  logic [CW-1:0] ref_i,
  input  logic [CW-1:0] code_i,
  output logic [1:0]    stat_o,
  output logic [AW-1:0] err_byte_o,
  output logic [2:0]    err_bit_o
);
  logic [CW-1:0] ref_q, syn;
  logic [AW-1:0] l_hi, l_lo;
  logic [COL_W-1:0] c_hi, c_lo;
  logic pairs_ok;
  hecc_stat_e stat;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       ref_q <= '0;
    else if (ref_wr_i) ref_q <= ref_i;
  end

  assign syn = ref_q ^ code_i;
  assign {l_hi, l_lo, c_hi, c_lo} = syn;
  assign pairs_ok = &{l_hi ^ l_lo, c_hi ^ c_lo};

  always_comb begin
    if (syn == '0)                 stat = HS_CLEAN;
    else if (pairs_ok)             stat = HS_FIX;
    else if ($countones(syn) == 1) stat = HS_PARITY;
    else                           stat = HS_MULTI;
  end

  assign stat_o     = stat;
  assign err_byte_o = (stat == HS_FIX) ? l_hi : '0;
  assign err_bit_o  = (stat == HS_FIX) ? c_hi : '0;
endmodule

// File: rtl/nand_hecc.sv
module nand_hecc
  import nand_hecc_pkg::*;
#(
  parameter int MAIN_BYTES  = 2048,
  parameter int SPARE_BYTES = 64,
  localparam int MAIN_AW  = $clog2(MAIN_BYTES),
  localparam int SPARE_AW = $clog2(SPARE_BYTES),
  localparam int MAIN_CW  = 2*MAIN_AW + 2*COL_W,
  localparam int SPARE_CW = 2*SPARE_AW + 2*COL_W
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                ecc_mode_i,
  input  logic                byte_vld_i,
  input  logic [7:0]          byte_i,
  input  logic                main_init_i,
  input  logic                main_lock_i,
  input  logic                spare_init_i,
  input  logic                spare_lock_i,
  input  logic                main_ref_wr_i,
  input  logic [MAIN_CW-1:0]  main_ref_i,
  input  logic                spare_ref_wr_i,
  input  logic [SPARE_CW-1:0] spare_ref_i,
  output logic [MAIN_CW-1:0]  main_code_o,
  output logic [SPARE_CW-1:0] spare_code_o,
  output logic [1:0]          main_stat_o,
  output logic [MAIN_AW-1:0]  main_err_byte_o,
  output logic [2:0]          main_err_bit_o,
  output logic [1:0]          spare_stat_o,
  output logic [SPARE_AW-1:0] spare_err_byte_o,
  output logic [2:0]          spare_err_bit_o
);
  logic live;
  assign live = byte_vld_i & ~ecc_mode_i;

  nand_hecc_acc #(.AW(MAIN_AW)) i_main_acc (
    .clk_i, .rst_ni,
    .init_i (main_init_i),
    .upd_i  (live & ~main_lock_i),
    .byte_i,
    .code_o (main_code_o)
  );

  nand_hecc_acc #(.AW(SPARE_AW)) i_spare_acc (
    .clk_i, .rst_ni,
    .init_i (spare_init_i),
    .upd_i  (live & ~spare_lock_i),
    .byte_i,
    .code_o (spare_code_o)
  );

  nand_hecc_chk #(.AW(MAIN_AW)) i_main_chk (
    .clk_i, .rst_ni,
    .ref_wr_i   (main_ref_wr_i),
    .ref_i      (main_ref_i),
    .code_i     (main_code_o),
    .stat_o     (main_stat_o),
    .err_byte_o (main_err_byte_o),
    .err_bit_o  (main_err_bit_o)
  );

  nand_hecc_chk #(.AW(SPARE_AW)) i_spare_chk (
    .clk_i, .rst_ni,
    .ref_wr_i   (spare_ref_wr_i),
    .ref_i      (spare_ref_i),
    .code_i     (spare_code_o),
    .stat_o     (spare_stat_o),
    .err_byte_o (spare_err_byte_o),
    .err_bit_o  (spare_err_bit_o)
  );
endmodule

// File: rtl/nand_hecc_sva.sv
module nand_hecc_sva #(
  parameter int MAIN_AW  = 11,
  parameter int SPARE_AW = 6,
  localparam int MAIN_CW  = 2*MAIN_AW + 6,
  localparam int SPARE_CW = 2*SPARE_AW + 6
) (
  input logic                clk_i,
  input logic                rst_ni,
  input logic                ecc_mode_i,
  input logic                main_init_i,
  input logic                main_lock_i,
  input logic                spare_init_i,
  input logic                spare_lock_i,
  input logic                main_ref_wr_i,
  input logic [MAIN_CW-1:0]  main_code_o,
  input logic [SPARE_CW-1:0] spare_code_o,
  input logic [1:0]          main_stat_o,
  input logic [MAIN_AW-1:0]  main_err_byte_o,
  input logic [2:0]          main_err_bit_o,
  input logic [1:0]          spare_stat_o,
  input logic [SPARE_AW-1:0] spare_err_byte_o,
  input logic [2:0]          spare_err_bit_o
);
  AST_MAIN_LOCK_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (main_lock_i && !main_init_i) |=> $stable(main_code_o)); // R2
  AST_MAIN_INIT_CLR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    main_init_i |=> (main_code_o == '0)); // R3
  AST_SPARE_INIT_CLR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    spare_init_i |=> (spare_code_o == '0)); // R3
  AST_SPARE_LOCK_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (spare_lock_i && !spare_init_i) |=> $stable(spare_code_o)); // R4
  AST_MODE_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ecc_mode_i && !main_init_i && !spare_init_i) |=>
      ($stable(main_code_o) && $stable(spare_code_o))); // R5
  AST_MAIN_LOC_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (main_stat_o != 2'b01) |-> (main_err_byte_o == '0 && main_err_bit_o == '0)); // R10
  AST_SPARE_LOC_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (spare_stat_o != 2'b01) |-> (spare_err_byte_o == '0 && spare_err_bit_o == '0)); // R10
  AST_MAIN_STAT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (main_lock_i && !main_init_i && !main_ref_wr_i) |=>
      ($stable(main_stat_o) && $stable(main_err_byte_o))); // R11
endmodule

bind nand_hecc nand_hecc_sva #(.MAIN_AW(MAIN_AW), .SPARE_AW(SPARE_AW)) i_sva (.*);

// File: tb/test_nand_hecc.sv
module test_nand_hecc;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic        ecc_mode, vld, m_init, m_lock, s_init, s_lock, m_wr, s_wr;
  logic [7:0]  dbyte;
  logic [27:0] m_ref, m_code;
  logic [17:0] s_ref, s_code;
  logic [1:0]  m_stat, s_stat;
  logic [10:0] m_ebyte;
  logic [5:0]  s_ebyte;
  logic [2:0]  m_ebit, s_ebit;

  nand_hecc i_nand_hecc (
    .clk_i(clk), .rst_ni(rst_n), .ecc_mode_i(ecc_mode),
    .byte_vld_i(vld), .byte_i(dbyte),
    .main_init_i(m_init), .main_lock_i(m_lock),
    .spare_init_i(s_init), .spare_lock_i(s_lock),
    .main_ref_wr_i(m_wr), .main_ref_i(m_ref),
    .spare_ref_wr_i(s_wr), .spare_ref_i(s_ref),
    .main_code_o(m_code), .spare_code_o(s_code),
    .main_stat_o(m_stat), .main_err_byte_o(m_ebyte), .main_err_bit_o(m_ebit),
    .spare_stat_o(s_stat), .spare_err_byte_o(s_ebyte), .spare_err_bit_o(s_ebit)
  );

  int n_chk = 0;
  int n_fail = 0;
  logic [7:0] buf_q [0:63];

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [27:0] model(input int n, input int aw);
    logic [10:0] lh = '0, ll = '0;
    logic [2:0]  ch = '0, cl = '0;
    logic [27:0] r = '0;
    for (int i = 0; i < n; i++)
      for (int b = 0; b < 8; b++)
        if (buf_q[i][b]) begin
          for (int j = 0; j < 3; j++)
            if (((b >> j) & 1) == 1) ch[j] = ~ch[j]; else cl[j] = ~cl[j];
          for (int k = 0; k < aw; k++)
            if ((((i % 64) >> k) & 1) == 1) lh[k] = ~lh[k]; else ll[k] = ~ll[k];
        end
    r[2:0] = cl;
    r[5:3] = ch;
    for (int k = 0; k < aw; k++) begin
      r[6+k]    = ll[k];
      r[6+aw+k] = lh[k];
    end
    return r;
  endfunction

  task automatic send(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); vld = 1'b1; dbyte = buf_q[i];
    end
    @(negedge clk); vld = 1'b0;
  endtask

  task automatic fill(input int n, input int seed);
    for (int i = 0; i < n; i++) buf_q[i] = 8'((i * 37 + seed) ^ (i >> 2));
  endtask

  task automatic pulse_m_init;
    @(negedge clk); m_init = 1'b1;
    @(negedge clk); m_init = 1'b0;
  endtask

  task automatic load_mref(input logic [27:0] v);
    @(negedge clk); m_wr = 1'b1; m_ref = v;
    @(negedge clk); m_wr = 1'b0;
  endtask

  task automatic t_reset;
    chk("R3 reset main code", 32'(m_code), 0);
    chk("R3 reset spare code", 32'(s_code), 0);
    chk("R6 reset status", 32'(m_stat), 0);
  endtask

  task automatic t_main;
    fill(40, 5);
    pulse_m_init();
    m_lock = 1'b0;
    send(40);
    chk("R1 main code", 32'(m_code), 32'(model(40, 11)));
    chk("R4 spare untouched", 32'(s_code), 0);
  endtask

  task automatic t_lock;
    logic [27:0] held;
    held = m_code;
    m_lock = 1'b1;
    fill(10, 99);
    send(10);
    chk("R2 lock freezes", 32'(m_code), 32'(held));
  endtask

  task automatic t_compare;
    logic [27:0] good;
    fill(40, 5);
    good = model(40, 11);
    load_mref(good);
    chk("R6 clean status", 32'(m_stat), 0);
    chk("R10 clean loc", 32'({m_ebyte, m_ebit}), 0);
    buf_q[37][6] = ~buf_q[37][6];
    load_mref(model(40, 11));
    chk("R7 fix status", 32'(m_stat), 1);
    chk("R7 err byte", 32'(m_ebyte), 37);
    chk("R7 err bit", 32'(m_ebit), 6);
    fill(10, 99);
    send(10);
    chk("R11 status holds", 32'({m_stat, m_ebyte, m_ebit}), 32'({2'b01, 11'd37, 3'd6}));
    fill(40, 5);
    buf_q[3][0] = ~buf_q[3][0];
    buf_q[20][5] = ~buf_q[20][5];
    load_mref(model(40, 11));
    chk("R8 multi status", 32'(m_stat), 2);
    chk("R10 multi loc", 32'({m_ebyte, m_ebit}), 0);
    load_mref(good ^ 28'h0000100);
    chk("R9 parity status", 32'(m_stat), 3);
  endtask

  task automatic t_spare;
    fill(64, 11);
    buf_q[63] = 8'hA5;
    @(negedge clk); s_init = 1'b1;
    @(negedge clk); s_init = 1'b0; s_lock = 1'b0;
    send(64);
    s_lock = 1'b1;
    chk("R4 spare code 64 bytes", 32'(s_code), 32'(model(64, 6)));
    buf_q[63][7] = ~buf_q[63][7];
    @(negedge clk); s_wr = 1'b1; s_ref = 18'(model(64, 6));
    @(negedge clk); s_wr = 1'b0;
    chk("R7 spare fix", 32'({s_stat, s_ebyte, s_ebit}), 32'({2'b01, 6'd63, 3'd7}));
    chk("R4 main held", 32'(m_stat), 3);
  endtask

  task automatic t_mode;
    logic [27:0] mh;
    logic [17:0] sh;
    mh = m_code; sh = s_code;
    ecc_mode = 1'b1; m_lock = 1'b0; s_lock = 1'b0;
    fill(8, 3);
    send(8);
    chk("R5 main idle", 32'(m_code), 32'(mh));
    chk("R5 spare idle", 32'(s_code), 32'(sh));
    ecc_mode = 1'b0; m_lock = 1'b1; s_lock = 1'b1;
  endtask

  task automatic t_init;
    pulse_m_init();
    chk("R3 init clears", 32'(m_code), 0);
    m_lock = 1'b0;
    fill(12, 77);
    send(12);
    m_lock = 1'b1;
    chk("R3 index restarts", 32'(m_code), 32'(model(12, 11)));
  endtask

  initial begin
    ecc_mode = 0; vld = 0; dbyte = 0; m_init = 0; s_init = 0;
    m_lock = 1; s_lock = 1; m_wr = 0; s_wr = 0; m_ref = 0; s_ref = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_main();
    t_lock();
    t_compare();
    t_spare();
    t_mode();
    t_init();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule